// File: doc/BRIEF.md
# Alternating Trigger Group Dispatcher

This block sends successive external triggers for a converter pair's priority channel group to the two converters in turn. The first accepted trigger asks converter 0's sequencer to run its whole group. The next accepted trigger asks converter 1's sequencer to run its group. The rotation then continues in the same way. One trigger source is picked out of a bank of asynchronous trigger lines by a select input. That line is synchronised and its rising edge is detected.

The sequencers report back with a one-cycle group-done pulse. Each converter has its own sticky end-of-group flag, with a write-one clear input and an interrupt enable. A trigger that arrives while a group is still running is not queued. It is dropped and it sets a sticky overrun flag. Turning the mode off parks the rotation so that the next trigger goes to converter 0.

Top module: `alt_trig_dispatch`

## Requirements
- R1: Only the line indexed by `trig_sel` (binary index into `ext_trig`) can start a group. Edges on every other line have no effect on `grp_start` or `ovr_flag`.
- R2: The selected line is sampled by `SYNC_STAGES` flip-flops and then edge-detected. With the default of 2, `grp_start` rises after the fourth rising clock edge that samples the line high, and it stays high for exactly one cycle. A line held high gives only one start.
- R3: `grp_start` is one-hot or zero. Bit 0 requests converter 0 and bit 1 requests converter 1. After reset, accepted triggers go to 0, 1, 0, 1 and so on.
- R4: A trigger detected while a group is running does not start a group and does not advance the rotation. It sets `ovr_flag` on the next edge. `ovr_flag` stays set until `ovr_clr` is high at a clock edge.
- R5: A `grp_done[i]` pulse from the converter whose group is running sets `eog_flag[i]` on that edge. A done pulse from a converter that is not running is ignored.
- R6: `eog_irq[i]` is high exactly when the registered `eog_flag[i]` is set and `eog_ie[i]` was high at the edge that updated it.
- R7: `eog_clr[i]` high at an edge clears `eog_flag[i]`. If a set happens on the same edge, the set wins.
- R8: While `mode_en` is low, no group starts, no overrun is recorded and the rotation returns to converter 0. Group tracking is cleared.
- R9: A trigger that arrives after converter 1's group has completed starts converter 0 again.
- R10: Synchronous active-high `rst` clears all outputs and internal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_en | input | 1 | Enables alternating dispatch |
| trig_sel | input | $clog2(N_TRIG) | Index of the trigger line in use |
| ext_trig | input | N_TRIG | Asynchronous trigger lines |
| grp_done | input | 2 | Group-complete pulses from the two sequencers |
| eog_clr | input | 2 | Write-one clears for the end-of-group flags |
| eog_ie | input | 2 | Interrupt enables per converter |
| ovr_clr | input | 1 | Clears the overrun flag |
| grp_start | output | 2 | One-cycle group start requests |
| eog_flag | output | 2 | Sticky end-of-group flags |
| eog_irq | output | 2 | Gated end-of-group interrupts |
| ovr_flag | output | 1 | Sticky dropped-trigger flag |

## Verification
The bench builds the block with eight trigger lines and two synchroniser stages. This makes the exact four-edge start latency observable. It also lets the select be moved between distant lines such as 3 and 6. The sequencer model's latency can be changed at run time, from short groups to groups of 30 cycles. This reaches back-to-back rotation as well as triggers that land during a running group. Forced done pulses reach the idle-converter and set-versus-clear corners.

// File: rtl/atd_pkg.sv
package atd_pkg;
  localparam int NCONV = 2;
  typedef logic [NCONV-1:0] conv_vec_t;
  typedef enum logic {ROT_IDLE = 1'b0, ROT_BUSY = 1'b1} rot_state_t;
endpackage

// File: rtl/atd_trig_front.sv
module atd_trig_front #(
  parameter int N_TRIG      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_TRIG-1:0]         ext_trig,
  input  logic [$clog2(N_TRIG)-1:0] trig_sel,
  output logic                      trig_pulse
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][N_TRIG-1:0] sync_q;
  logic line_now;
  logic line_prev;

  // first stage captures the raw lines
  always_ff @(posedge clk) begin
    if (rst) sync_q[0] <= '0;
    else     sync_q[0] <= ext_trig;
  end

  // remaining stages form a plain shift chain
  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) sync_q[s] <= '0;
      else     sync_q[s] <= sync_q[s-1];
    end
  end

  assign line_now = sync_q[LAST][trig_sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      line_prev  <= 1'b0;
      trig_pulse <= 1'b0;
    end else begin
      line_prev  <= line_now;
      trig_pulse <= line_now & ~line_prev;
    end
  end

  // R2: an edge yields a single-cycle pulse
  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (rst)
    trig_pulse |=> !trig_pulse);
endmodule

// File: rtl/atd_rotator.sv
module atd_rotator
  import atd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      mode_en,
  input  logic      trig_pulse,
  input  conv_vec_t grp_done,
  input  logic      ovr_clr,
  output conv_vec_t grp_start,
  output conv_vec_t done_ok,
  output logic      ovr_flag
);
  rot_state_t state_q;
  logic       ptr_q;
  logic       act_q;
  logic       ovr_set;
  conv_vec_t  act_mask;

  assign act_mask = act_q ? 2'b10 : 2'b01;
  assign done_ok  = (mode_en && state_q == ROT_BUSY) ? (grp_done & act_mask) : '0;
  assign ovr_set  = mode_en & trig_pulse & (state_q == ROT_BUSY);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ROT_IDLE;
      ptr_q     <= 1'b0;
      act_q     <= 1'b0;
      grp_start <= '0;
      ovr_flag  <= 1'b0;
    end else begin
      grp_start <= '0;
      if (!mode_en) begin
        state_q <= ROT_IDLE;
        ptr_q   <= 1'b0;
      end else begin
        if (|done_ok) state_q <= ROT_IDLE;
        if (trig_pulse && state_q == ROT_IDLE) begin
          grp_start[ptr_q] <= 1'b1;
          state_q          <= ROT_BUSY;
          act_q            <= ptr_q;
          ptr_q            <= ~ptr_q;
        end
      end
      ovr_flag <= ovr_set | (ovr_flag & ~ovr_clr);
    end
  end

  // R3: never request both converters at once
  assert_start_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grp_start));
  // R4: a trigger during a running group is dropped and recorded
  assert_drop_busy_R4: assert property (@(posedge clk) disable iff (rst)
    (trig_pulse && mode_en && state_q == ROT_BUSY) |=> (grp_start == '0) && ovr_flag);
  // R4: overrun is sticky until cleared
  assert_ovr_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (ovr_flag && !ovr_clr) |=> ovr_flag);
  // R8: nothing starts while the mode is off
  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !mode_en |=> (grp_start == '0));
endmodule

// File: rtl/atd_flag_bank.sv
module atd_flag_bank
  import atd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  conv_vec_t done_ok,
  input  conv_vec_t eog_clr,
  input  conv_vec_t eog_ie,
  output conv_vec_t eog_flag,
  output conv_vec_t eog_irq
);
  for (genvar i = 0; i < NCONV; i++) begin : g_conv
    logic flag_q;
    logic irq_q;
    logic flag_nxt;

    // set takes priority over a same-edge clear
    assign flag_nxt = done_ok[i] | (flag_q & ~eog_clr[i]);

    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q <= 1'b0;
        irq_q  <= 1'b0;
      end else begin
        flag_q <= flag_nxt;
        irq_q  <= flag_nxt & eog_ie[i];
      end
    end

    assign eog_flag[i] = flag_q;
    assign eog_irq[i]  = irq_q;

    // R5: accepted completion sets the flag
    assert_done_sets_R5: assert property (@(posedge clk) disable iff (rst)
      done_ok[i] |=> eog_flag[i]);
    // R6: interrupt never without its flag
    assert_irq_gated_R6: assert property (@(posedge clk) disable iff (rst)
      eog_irq[i] |-> eog_flag[i]);
  end
endmodule

// File: rtl/alt_trig_dispatch.sv
module alt_trig_dispatch
  import atd_pkg::*;
#(
  parameter int N_TRIG      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      mode_en,
  input  logic [$clog2(N_TRIG)-1:0] trig_sel,
  input  logic [N_TRIG-1:0]         ext_trig,
  input  logic [1:0]                grp_done,
  input  logic [1:0]                eog_clr,
  input  logic [1:0]                eog_ie,
  input  logic                      ovr_clr,
  output logic [1:0]                grp_start,
  output logic [1:0]                eog_flag,
  output logic [1:0]                eog_irq,
  output logic                      ovr_flag
);
  logic      trig_pulse;
  conv_vec_t done_ok;

  atd_trig_front #(
    .N_TRIG      (N_TRIG),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_front (
    .clk        (clk),
    .rst        (rst),
    .ext_trig   (ext_trig),
    .trig_sel   (trig_sel),
    .trig_pulse (trig_pulse)
  );

  atd_rotator u_rot (
    .clk        (clk),
    .rst        (rst),
    .mode_en    (mode_en),
    .trig_pulse (trig_pulse),
    .grp_done   (grp_done),
    .ovr_clr    (ovr_clr),
    .grp_start  (grp_start),
    .done_ok    (done_ok),
    .ovr_flag   (ovr_flag)
  );

  atd_flag_bank u_flags (
    .clk      (clk),
    .rst      (rst),
    .done_ok  (done_ok),
    .eog_clr  (eog_clr),
    .eog_ie   (eog_ie),
    .eog_flag (eog_flag),
    .eog_irq  (eog_irq)
  );
endmodule

// File: tb/alt_trig_dispatch_bench.sv
module alt_trig_dispatch_bench;
  localparam int N_TRIG = 8;
  localparam int SYNC   = 2;
  localparam int SELW   = $clog2(N_TRIG);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_en = 1'b0;
  logic [SELW-1:0] trig_sel = '0;
  logic [N_TRIG-1:0] ext_trig = '0;
  logic [1:0] grp_done = '0;
  logic [1:0] eog_clr = '0;
  logic [1:0] eog_ie = '0;
  logic ovr_clr = 1'b0;
  logic [1:0] grp_start, eog_flag, eog_irq;
  logic ovr_flag;

  always #2 clk = ~clk;

  alt_trig_dispatch #(.N_TRIG(N_TRIG), .SYNC_STAGES(SYNC)) u_alt_trig_dispatch (
    .clk(clk), .rst(rst), .mode_en(mode_en), .trig_sel(trig_sel),
    .ext_trig(ext_trig), .grp_done(grp_done), .eog_clr(eog_clr),
    .eog_ie(eog_ie), .ovr_clr(ovr_clr), .grp_start(grp_start),
    .eog_flag(eog_flag), .eog_irq(eog_irq), .ovr_flag(ovr_flag));

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [N_TRIG-1:0] hist [0:SYNC+1];
  int  m_busy, m_ptr, m_act;
  logic [1:0] m_start, m_flag, m_irq;
  logic m_ovr;

  always @(posedge clk) begin
    bit trig;
    logic [1:0] ok_done, fnext;
    if (rst) begin
      for (int j = 0; j <= SYNC + 1; j++) hist[j] = '0;
      m_busy = 0; m_ptr = 0; m_act = 0;
      m_start = '0; m_flag = '0; m_irq = '0; m_ovr = 1'b0;
    end else begin
      trig = hist[SYNC][trig_sel] && !hist[SYNC+1][trig_sel];
      for (int j = SYNC + 1; j > 0; j--) hist[j] = hist[j-1];
      hist[0] = ext_trig;
      ok_done = '0;
      if (mode_en && m_busy != 0) ok_done[m_act] = grp_done[m_act];
      m_start = '0;
      m_ovr = (mode_en && trig && m_busy != 0) || (m_ovr && !ovr_clr);
      if (!mode_en) begin
        m_busy = 0; m_ptr = 0;
      end else begin
        int was_busy;
        was_busy = m_busy;
        if (ok_done != 0) m_busy = 0;
        if (trig && was_busy == 0) begin
          m_start[m_ptr] = 1'b1;
          m_busy = 1; m_act = m_ptr; m_ptr = 1 - m_ptr;
        end
      end
      fnext = ok_done | (m_flag & ~eog_clr);
      m_flag = fnext;
      m_irq  = fnext & eog_ie;
    end
  end

  // per-cycle comparison and start bookkeeping
  int n_start = 0;
  int last_tgt = -1;
  always @(negedge clk) begin
    if (!rst) begin
      chk(grp_start == m_start, "R3", "grp_start vs model", grp_start, m_start);
      chk(eog_flag == m_flag, "R5", "eog_flag vs model", eog_flag, m_flag);
      chk(eog_irq == m_irq, "R6", "eog_irq vs model", eog_irq, m_irq);
      chk(ovr_flag == m_ovr, "R4", "ovr_flag vs model", ovr_flag, m_ovr);
      if (grp_start != 0) begin
        n_start++;
        last_tgt = grp_start[1] ? 1 : 0;
      end
    end
  end

  // ---------------- sequencer model ----------------
  int seq_lat = 5;
  bit auto_en = 1'b1;
  logic [1:0] force_done = '0;
  int cnt [2] = '{0, 0};
  always @(negedge clk) begin
    logic [1:0] dv;
    dv = '0;
    for (int i = 0; i < 2; i++) begin
      if (cnt[i] == 1) dv[i] = 1'b1;
      if (cnt[i] > 0) cnt[i]--;
      if (grp_start[i] && auto_en) cnt[i] = seq_lat;
    end
    grp_done <= dv | force_done;
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fire(input int idx);
    @(negedge clk); ext_trig[idx] = 1'b1;
    wait_n(2);     ext_trig[idx] = 1'b0;
    wait_n(6);
  endtask

  initial begin
    int s0;
    wait_n(4);
    rst = 1'b0; mode_en = 1'b1; eog_ie = 2'b11; trig_sel = 3;
    @(negedge clk);
    // R10
    chk(grp_start == 0 && eog_flag == 0 && eog_irq == 0 && ovr_flag == 0,
        "R10", "outputs after reset", {grp_start, eog_flag, eog_irq, ovr_flag}, 0);

    // R2: exact latency, single start on a held line
    @(negedge clk); ext_trig[3] = 1'b1;
    wait_n(3);
    chk(grp_start == 2'b00, "R2", "no start before fourth edge", grp_start, 0);
    wait_n(1);
    chk(grp_start == 2'b01, "R2", "start on fourth edge to conv0 (R3)", grp_start, 1);
    wait_n(1);
    chk(grp_start == 2'b00, "R2", "start lasts one cycle", grp_start, 0);
    wait_n(10);
    ext_trig[3] = 1'b0;
    chk(n_start == 1, "R2", "held line gives one start", n_start, 1);
    wait_n(4);
    chk(eog_flag[0] == 1'b1 && eog_irq[0] == 1'b1, "R5", "conv0 done flag and irq",
        {eog_flag[0], eog_irq[0]}, 3);

    // R3: second trigger goes to conv1
    fire(3);
    chk(last_tgt == 1, "R3", "second trigger target", last_tgt, 1);
    wait_n(6);
    chk(eog_flag == 2'b11, "R5", "both flags set", eog_flag, 3);

    // R7: clear
    @(negedge clk); eog_clr = 2'b11;
    @(negedge clk); eog_clr = 2'b00;
    chk(eog_flag == 2'b00 && eog_irq == 2'b00, "R7", "flags cleared", eog_flag, 0);

    // R9: restart with conv0
    fire(3);
    chk(last_tgt == 0, "R9", "rotation restarts at conv0", last_tgt, 0);
    wait_n(6);

    // R1: unselected line ignored, then reselect
    s0 = n_start;
    fire(5);
    wait_n(4);
    chk(n_start == s0 && ovr_flag == 1'b0, "R1", "unselected line ignored", n_start, s0);
    trig_sel = 6;
    wait_n(2);
    fire(6);
    chk(n_start == s0 + 1 && last_tgt == 1, "R1", "newly selected line starts conv1",
        last_tgt, 1);
    wait_n(6);

    // R4: overrun with long groups
    seq_lat = 30;
    fire(6);
    chk(last_tgt == 0, "R4", "long group on conv0", last_tgt, 0);
    s0 = n_start;
    fire(6);
    chk(n_start == s0, "R4", "busy trigger dropped", n_start, s0);
    chk(ovr_flag == 1'b1, "R4", "overrun flag set", ovr_flag, 1);
    wait_n(30);
    chk(ovr_flag == 1'b1, "R4", "overrun sticky", ovr_flag, 1);
    fire(6);
    chk(last_tgt == 1, "R4", "pointer not advanced by dropped trigger", last_tgt, 1);
    @(negedge clk); ovr_clr = 1'b1;
    @(negedge clk); ovr_clr = 1'b0;
    chk(ovr_flag == 1'b0, "R4", "overrun cleared", ovr_flag, 0);
    wait_n(30);
    seq_lat = 5;

    // R6: interrupt gated by enable
    @(negedge clk); eog_clr = 2'b11;
    @(negedge clk); eog_clr = 2'b00; eog_ie = 2'b10;
    fire(6);
    wait_n(6);
    chk(eog_flag[0] == 1'b1 && eog_irq[0] == 1'b0, "R6", "flag without irq",
        eog_irq[0], 0);

    // R5 idle done ignored, R7 set beats clear
    auto_en = 1'b0;
    @(negedge clk); eog_clr = 2'b11;
    @(negedge clk); eog_clr = 2'b00;
    @(negedge clk); force_done = 2'b01;
    @(negedge clk); force_done = 2'b00;
    wait_n(2);
    chk(eog_flag == 2'b00, "R5", "done from idle converter ignored", eog_flag, 0);
    fire(6);
    chk(last_tgt == 1, "R3", "manual group on conv1", last_tgt, 1);
    @(negedge clk); force_done = 2'b10; eog_clr = 2'b10;
    @(negedge clk); force_done = 2'b00; eog_clr = 2'b00;
    wait_n(1);
    chk(eog_flag[1] == 1'b1, "R7", "set wins over same-edge clear", eog_flag[1], 1);
    auto_en = 1'b1;

    // R8: disable resets rotation and ignores triggers
    fire(6);
    chk(last_tgt == 0, "R8", "conv0 before disable", last_tgt, 0);
    wait_n(8);
    @(negedge clk); mode_en = 1'b0;
    s0 = n_start;
    fire(6);
    wait_n(2);
    chk(n_start == s0 && ovr_flag == 1'b0, "R8", "disabled: no start, no overrun",
        n_start, s0);
    mode_en = 1'b1;
    wait_n(2);
    fire(6);
    chk(last_tgt == 0, "R8", "re-enable restarts at conv0", last_tgt, 0);
    wait_n(10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule